// File: doc/BRIEF.md
# Instruction Cycle Control Sequencer

This block is the multicycle control unit of a small accumulator machine. Every instruction passes through a fetch subcycle, an optional indirect-address subcycle, an execute subcycle, and an optional interrupt subcycle. The work is done in a register set made of a program counter, a memory address register, a memory buffer register, an instruction register and an accumulator. It drives one synchronous single-port memory through an address, write data, read data, a read request and a write request. Memory reads have one cycle of latency, and the sequencer waits one cycle for each read.

An instruction word is 16 bits. Bits [15:13] hold the opcode, bit [12] is the indirect flag and bits [11:0] are the address field. The execute subcycle does load, store, add and unconditional jump. The interrupt subcycle saves the program counter to a fixed save word through the buffer register and then vectors to a fixed handler address. It runs only at the end of execute, and only while interrupts are enabled. An external pulse enables interrupts, and taking an interrupt disables them again. A one-hot phase output shows which subcycle is active.

Top module: `icseq_top`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears the program counter, the accumulator and the interrupt enable, selects the fetch phase (state_onehot = 4'b0001), and drives neither mem_rd nor mem_wr.
- R2: Fetch lasts 4 cycles. In its second cycle it drives mem_rd with mem_addr equal to the program counter. In that same cycle the program counter increments by one. The returned word becomes the instruction.
- R3: Instruction encoding: bits [15:13] are the opcode (3'b001 load, 3'b010 store, 3'b011 add, 3'b100 jump, any other value is a one-cycle no-op), bit [12] is the indirect flag and bits [11:0] are the address field.
- R4: When the indirect flag is 1, a 3-cycle indirect subcycle runs between fetch and execute. It reads the word at the address field, and the low 12 bits of that word become the effective address. When the flag is 0, the address field is the effective address and no indirect cycle occurs.
- R5: Load sets the accumulator to the memory word at the effective address. Execute takes 4 cycles.
- R6: Add sets the accumulator to the accumulator plus the memory word at the effective address, modulo 2^16. Execute takes 4 cycles.
- R7: Store writes the accumulator to the effective address with one mem_wr pulse, and the accumulator is unchanged. Execute takes 3 cycles.
- R8: Jump loads the program counter with the effective address. Execute takes 1 cycle.
- R9: When irq is 1 and interrupts are enabled at the last execute cycle, a 2-cycle interrupt subcycle follows. It writes the program counter to address SAVE_ADDR (0), loads the program counter with HANDLER_ADDR (1) and clears the interrupt enable. The next fetch reads address 1.
- R10: While the interrupt enable is 0, irq has no effect and no interrupt subcycle occurs.
- R11: state_onehot is always one-hot: bit 0 fetch, bit 1 indirect, bit 2 execute, bit 3 interrupt.
- R12: mem_rd and mem_wr are never high in the same cycle.
- R13: A high ie_set at a clock edge sets the interrupt enable, and int_en reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq | input | 1 | External interrupt request |
| ie_set | input | 1 | Sets the interrupt enable |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| mem_addr | output | 12 | Memory address (address register) |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| pc | output | 12 | Program counter |
| acc | output | 16 | Accumulator |
| int_en | output | 1 | Interrupt enable status |
| state_onehot | output | 4 | Active subcycle, one-hot |

## Verification
The main sweep runs every opcode, plus one unassigned code, with the indirect flag both clear and set. It checks the accumulator, the target memory word, the program counter and the cycles spent in each phase. This separates the opcode decode, the effective-address selection and the length of each subcycle. The add operands wrap past 2^16, so the arithmetic has to be modulo. The interrupt runs follow a jump, so the saved program counter differs from the handler address. They compare an enabled request against a held request with interrupts disabled, which also shows that the handler is not re-entered.

// File: rtl/icseq_pkg.sv
// Package: shared phase type and opcode values for the instruction sequencer.
// Assumes a 3-bit opcode field at the top of the instruction word.
package icseq_pkg;
    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_IND   = 2'd1,
        PH_EXEC  = 2'd2,
        PH_INT   = 2'd3
    } phase_t;

    localparam logic [2:0] OP_LOAD  = 3'b001;
    localparam logic [2:0] OP_STORE = 3'b010;
    localparam logic [2:0] OP_ADD   = 3'b011;
    localparam logic [2:0] OP_JUMP  = 3'b100;
endpackage

// File: rtl/icseq_fsm.sv
// Module: icseq_fsm
// Steps the instruction cycle through its phases, with a step counter
// inside each phase. The last step of each phase depends on the phase and,
// in execute, on the opcode. Assumes that the datapath supplies the
// instruction-register opcode, the indirect bit of the buffer register
// (valid at the last fetch step) and the interrupt-take condition.
module icseq_fsm
    import icseq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ind_bit,
    input  logic [2:0]   opcode,
    input  logic         irq_take,
    output phase_t       phase,
    output logic [1:0]   step
);
    logic [1:0] last_step;
    phase_t     next_phase;

    // Purpose: number of the final step in the current phase.
    always_comb begin
        unique case (phase)
            PH_FETCH: last_step = 2'd3;
            PH_IND:   last_step = 2'd2;
            PH_EXEC:  begin
                if (opcode == OP_LOAD || opcode == OP_ADD) last_step = 2'd3;
                else if (opcode == OP_STORE)               last_step = 2'd2;
                else                                       last_step = 2'd0;
            end
            default:  last_step = 2'd1;
        endcase
    end

    // Purpose: choose the phase that follows the current one.
    always_comb begin
        unique case (phase)
            PH_FETCH: next_phase = ind_bit ? PH_IND : PH_EXEC;
            PH_IND:   next_phase = PH_EXEC;
            PH_EXEC:  next_phase = irq_take ? PH_INT : PH_FETCH;
            default:  next_phase = PH_FETCH;
        endcase
    end

    // Purpose: advance the step, or move to the next phase after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_FETCH;
            step  <= 2'd0;
        end else if (step == last_step) begin
            phase <= next_phase;
            step  <= 2'd0;
        end else begin
            step  <= step + 2'd1;
        end
    end

    a_r4_ind_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IND && step == 2'd0) |-> $past(phase) == PH_FETCH);
    a_r9_int_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INT && step == 2'd0) |-> $past(phase) == PH_EXEC);
    a_r3_exec_from_fetch_or_ind: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && step == 2'd0) |-> ($past(phase) == PH_FETCH || $past(phase) == PH_IND));
endmodule

// File: rtl/icseq_datapath.sv
// Module: icseq_datapath
// Holds PC, MAR, MBR, IR, the accumulator and the interrupt enable.
// Performs the register transfers of each phase and step. Assumes a
// synchronous memory whose read data is valid one cycle after the request.
module icseq_datapath
    import icseq_pkg::*;
#(
    parameter int AW           = 12,
    parameter int DW           = 16,
    parameter int SAVE_ADDR    = 0,
    parameter int HANDLER_ADDR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase,
    input  logic [1:0]    step,
    input  logic          irq,
    input  logic          ie_set,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] acc,
    output logic          ie,
    output logic [2:0]    ir_op,
    output logic          mbr_ind,
    output logic          irq_take
);
    localparam int OP_HI  = DW - 1;
    localparam int IND_BT = DW - 4;

    logic [AW-1:0] mar;
    logic [DW-1:0] mbr;
    logic [DW-1:0] ir;
    logic          op_mem_rd;

    assign ir_op     = ir[OP_HI -: 3];
    assign mbr_ind   = mbr[IND_BT];
    assign irq_take  = irq && ie;
    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign op_mem_rd = (ir_op == OP_LOAD) || (ir_op == OP_ADD);

    // Purpose: issue memory read and write requests for the current step.
    always_comb begin
        mem_rd = (step == 2'd1) &&
                 (phase == PH_FETCH || phase == PH_IND || (phase == PH_EXEC && op_mem_rd));
        mem_wr = (phase == PH_EXEC && step == 2'd2 && ir_op == OP_STORE) ||
                 (phase == PH_INT  && step == 2'd1);
    end

    // Purpose: register transfers for every phase and step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            acc <= '0;
            ie  <= 1'b0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
        end else begin
            if (ie_set) ie <= 1'b1;
            unique case (phase)
                PH_FETCH: begin
                    if (step == 2'd0) mar <= pc;
                    if (step == 2'd1) pc  <= pc + AW'(1);
                    if (step == 2'd2) mbr <= mem_rdata;
                    if (step == 2'd3) ir  <= mbr;
                end
                PH_IND: begin
                    if (step == 2'd0) mar <= mbr[AW-1:0];
                    if (step == 2'd2) mbr <= mem_rdata;
                end
                PH_EXEC: begin
                    if (step == 2'd0) begin
                        if (ir_op == OP_JUMP) pc  <= mbr[AW-1:0];
                        else                  mar <= mbr[AW-1:0];
                    end
                    if (step == 2'd1 && ir_op == OP_STORE) mbr <= acc;
                    if (step == 2'd2 && op_mem_rd)         mbr <= mem_rdata;
                    if (step == 2'd3 && ir_op == OP_LOAD)  acc <= mbr;
                    if (step == 2'd3 && ir_op == OP_ADD)   acc <= acc + mbr;
                end
                default: begin
                    if (step == 2'd0) begin
                        mbr <= DW'(pc);
                        mar <= AW'(SAVE_ADDR);
                    end
                    if (step == 2'd1) begin
                        pc <= AW'(HANDLER_ADDR);
                        ie <= 1'b0;
                    end
                end
            endcase
        end
    end

    a_r2_pc_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH && step == 2'd1) |=> pc == $past(pc) + AW'(1));
    a_r2_fetch_reads_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH && mem_rd) |-> mem_addr == pc);
    a_r12_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    a_r9_int_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INT && step == 2'd0) |-> ie);
    a_r9_vector_and_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INT && step == 2'd1) |=> (pc == AW'(HANDLER_ADDR) && !ie));
    a_r7_store_data_is_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && phase == PH_EXEC) |-> mem_wdata == acc);
    a_r13_ie_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_set && phase != PH_INT) |=> ie);
endmodule

// File: rtl/icseq_top.sv
// Module: icseq_top
// Multicycle instruction-cycle sequencer for an accumulator machine. It
// connects the phase FSM to the register datapath and exposes the active
// phase one-hot. Assumes DW >= AW + 4 (opcode, indirect bit, address field).
module icseq_top
    import icseq_pkg::*;
#(
    parameter int AW           = 12,
    parameter int DW           = 16,
    parameter int SAVE_ADDR    = 0,
    parameter int HANDLER_ADDR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq,
    input  logic          ie_set,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] acc,
    output logic          int_en,
    output logic [3:0]    state_onehot
);
    phase_t     phase;
    logic [1:0] step;
    logic [2:0] ir_op;
    logic       mbr_ind;
    logic       irq_take;

    icseq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ind_bit  (mbr_ind),
        .opcode   (ir_op),
        .irq_take (irq_take),
        .phase    (phase),
        .step     (step)
    );

    icseq_datapath #(
        .AW           (AW),
        .DW           (DW),
        .SAVE_ADDR    (SAVE_ADDR),
        .HANDLER_ADDR (HANDLER_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .step      (step),
        .irq       (irq),
        .ie_set    (ie_set),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .pc        (pc),
        .acc       (acc),
        .ie        (int_en),
        .ir_op     (ir_op),
        .mbr_ind   (mbr_ind),
        .irq_take  (irq_take)
    );

    // Purpose: decode the phase into the one-hot status output.
    always_comb begin
        state_onehot = 4'b0001 << phase;
    end

    a_r11_onehot_state: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_onehot));
    a_r1_no_request_at_phase_start: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 2'd0) |-> !(mem_rd || mem_wr));
endmodule

// File: tb/icseq_top_test.sv
// Bench for icseq_top: sweeps opcodes and the indirect flag, then runs the interrupt cases.
module icseq_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic        ie_set = 1'b0;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rd, mem_wr;
    logic [11:0] pc;
    logic [15:0] acc;
    logic        int_en;
    logic [3:0]  state_onehot;

    logic [15:0] mem [0:4095];
    int checks = 0, fails = 0, cycles = 0;
    int fetch_entries = 0, ind_cyc = 0, exe_cyc = 0, int_cyc = 0;
    int bad_onehot = 0, bad_rdwr = 0;
    logic [3:0]  prev_state = 4'b0001;
    logic [11:0] last_fetch_addr = '0;

    always #10 clk = ~clk;

    icseq_top uut (
        .clk(clk), .rst_n(rst_n), .irq(irq), .ie_set(ie_set),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .pc(pc), .acc(acc),
        .int_en(int_en), .state_onehot(state_onehot)
    );

    // Synchronous memory with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // Monitor: phase counters and per-cycle properties, sampled at negedge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (state_onehot[0] && !prev_state[0]) fetch_entries++;
            if (state_onehot[1]) ind_cyc++;
            if (state_onehot[2]) exe_cyc++;
            if (state_onehot[3]) int_cyc++;
            if ($countones(state_onehot) != 1) bad_onehot++;
            if (mem_rd && mem_wr) bad_rdwr++;
            if (mem_rd && state_onehot[0]) last_fetch_addr = mem_addr;
        end
        prev_state = state_onehot;
        if (cycles > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [2:0] op, input logic ind, input logic [11:0] a);
        return {op, ind, a};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        fetch_entries = 0; ind_cyc = 0; exe_cyc = 0; int_cyc = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_fetches(input int n);
        while (fetch_entries < n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;

        // R1: reset state.
        do_reset();
        check(state_onehot == 4'b0001, "R1 state", state_onehot, 4'b0001);
        check(pc == 0 && acc == 0, "R1 pc/acc", {pc, acc}, 0);
        check(int_en == 0, "R1 ie", int_en, 0);
        check(!mem_rd && !mem_wr, "R1 no request", {mem_rd, mem_wr}, 0);

        // Sweep: opcode x indirect flag. Program: LOAD 0x100, then the instruction under test.
        for (int k = 0; k < 10; k++) begin
            logic [2:0]  op;
            logic        ind;
            logic [15:0] a, b, exp_acc, exp_mem;
            logic [11:0] exp_pc;
            int          exp_exe;
            op  = (k / 2 == 4) ? 3'b101 : 3'(k / 2 + 1);
            ind = k[0];
            a   = 16'hFF00 + 16'(k * 16'h0111);
            b   = 16'h0345 + 16'(k * 16'h0023);
            mem[0]       = enc(3'b001, 1'b0, 12'h100);
            mem[1]       = enc(op, ind, ind ? 12'h300 : 12'h200);
            mem[12'h100] = a;
            mem[12'h200] = b;
            mem[12'h300] = 16'hE200;
            do_reset();
            wait_fetches(2);
            exp_acc = (op == 3'b001) ? b : (op == 3'b011) ? a + b : a;
            exp_mem = (op == 3'b010) ? a : b;
            exp_pc  = (op == 3'b100) ? 12'h200 : 12'd2;
            exp_exe = 4 + ((op == 3'b001 || op == 3'b011) ? 4 : (op == 3'b010) ? 3 : 1);
            check(acc == exp_acc, (op == 3'b011) ? "R6 add acc" : "R5 load acc", acc, exp_acc);
            check(mem[12'h200] == exp_mem, "R7 store mem", mem[12'h200], exp_mem);
            check(pc == exp_pc, "R8 jump pc", pc, exp_pc);
            check(exe_cyc == exp_exe, "R3 exec length", exe_cyc, exp_exe);
            check(ind_cyc == (ind ? 3 : 0), "R4 indirect cycles", ind_cyc, ind ? 3 : 0);
            check(last_fetch_addr == 12'd1, "R2 fetch address", last_fetch_addr, 1);
        end

        // R9/R13: enabled interrupt after a jump to 0x050; handler at 1 loads 0x101.
        mem[0]       = enc(3'b100, 1'b0, 12'h050);
        mem[1]       = enc(3'b001, 1'b0, 12'h101);
        mem[12'h101] = 16'hBEEF;
        do_reset();
        ie_set = 1'b1;
        @(negedge clk);
        ie_set = 1'b0;
        check(int_en == 1'b1, "R13 ie set", int_en, 1);
        irq = 1'b1;
        wait_fetches(1);
        @(negedge clk); @(negedge clk);
        check(int_cyc == 2, "R9 int cycles", int_cyc, 2);
        check(mem[0] == 16'h0050, "R9 saved pc", mem[0], 16'h0050);
        check(int_en == 1'b0, "R9 ie cleared", int_en, 0);
        check(last_fetch_addr == 12'd1, "R9 handler fetch", last_fetch_addr, 1);
        wait_fetches(2);
        check(acc == 16'hBEEF, "R9 handler ran", acc, 16'hBEEF);
        check(pc == 12'd2, "R9 handler pc", pc, 2);
        check(int_cyc == 2, "R10 no reentry", int_cyc, 2);

        // R10: irq held while interrupts are disabled.
        mem[0] = enc(3'b001, 1'b0, 12'h101);
        mem[1] = enc(3'b011, 1'b0, 12'h101);
        do_reset();
        wait_fetches(2);
        check(int_cyc == 0, "R10 irq ignored", int_cyc, 0);
        check(pc == 12'd2, "R10 pc", pc, 2);
        check(acc == 16'h7DDE, "R6 wrap", acc, 16'h7DDE);
        irq = 1'b0;

        check(bad_onehot == 0, "R11 onehot", bad_onehot, 0);
        check(bad_rdwr == 0, "R12 rd/wr exclusive", bad_rdwr, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule